// File: doc/BRIEF.md
# Four-Channel Periodic Interval Timer with Reset Trigger

This block gives a processor four down-counting interval timers behind a small word-addressed register window. Each channel holds a reload length and a live count. The count steps down once for every pulse on a shared single-cycle tick enable, which the system derives as a 1 MHz strobe. When a running channel's count reaches its end, that channel raises a sticky interrupt line and reloads itself, so it fires periodically every `length` ticks.

A single start/stop register controls all four channels in one write. It holds one 4-bit field per channel. The same window also holds a reset trigger. Writing one exact key value there produces a one-cycle request pulse towards the system reset logic. The interrupt controller and the reset logic that consume these outputs sit outside the block.

The register port is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read strobe returns its data on `bus_rdata` in the next cycle, and that value is held until the next read.

Top module: `quad_tick_timer`

## Requirements
- R1: After reset every count and every length is 0, all channels are stopped, every `timer_irq` bit is low and `reset_req` is low.
- R2: Writing a nonzero value to channel i's length register (byte offset 4*i, i = 0..3) stores it as the length and loads it into the count. It leaves the run state unchanged.
- R3: Writing zero to a channel's length register stops that channel and freezes its count at the current value.
- R4: On a write to the start/stop register (offset 0x10), channel i looks at data bits [4i+3:4i]. If that field is nonzero and the channel's length is nonzero, the count reloads from the length and the channel runs. Otherwise the channel stops and keeps its count.
- R5: A running channel's count drops by one on each cycle with `tick` high and holds on other cycles. A stopped channel ignores `tick`.
- R6: A tick that arrives when a running channel's count is 1 reloads the count from the length and sets that channel's `timer_irq` bit. After t ticks from a start, the count therefore equals L - (t mod L), where L is the length.
- R7: A `timer_irq` bit stays high until a write to that channel's length register or to the start/stop register. Writes to another channel's length register leave it high.
- R8: Reads at offset 0x14 + 4*i return channel i's live count. Every other offset reads as 0, including the length, start/stop and trigger offsets.
- R9: Writing exactly 0x0001_0000 to the trigger register (offset 0x34) makes `reset_req` high for exactly one cycle, in the cycle after the write. Any other value, or that value written at another offset, produces no pulse.
- R10: Each channel's length, count, run state and interrupt depend only on its own length writes and its own start/stop field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle count enable shared by all channels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| timer_irq | output | 4 | Sticky per-channel expiry interrupt |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps lengths 1 through 6 on every channel. It reads the count after each tick and compares it with L - (t mod L). An off-by-one in the expiry compare would show up here as a period of L+1 or L-1, and a length of 1 would either stall or never fire. Further tests aim at the edges of the start/stop fields and the interrupt clearing. A design that decoded the wrong field bits would start the wrong channel. One that cleared interrupts on any length write would drop another channel's pending interrupt. One that started a channel whose length is zero would be caught because its count moves. The trigger is probed with near-miss values and with the key at a neighbouring offset, which exposes a masked or partial compare. Its pulse is sampled over two cycles, which exposes a level instead of a pulse.

// File: rtl/qtt_pkg.sv
package qtt_pkg;
  // Register window layout (byte offsets)
  localparam int unsigned LEN_BASE   = 32'h00;
  localparam int unsigned RUN_OFS    = 32'h10;
  localparam int unsigned CNT_BASE   = 32'h14;
  localparam int unsigned TRIG_OFS   = 32'h34;
  localparam int unsigned WORD_BYTES = 4;

  localparam logic [31:0] TRIG_KEY = 32'h0001_0000;

  // Per-channel write actions produced by the decoder
  typedef struct packed {
    logic len_we;
    logic run_we;
  } ch_wr_t;
endpackage

// File: rtl/qtt_decode.sv
module qtt_decode
  import qtt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output ch_wr_t            ch_wr   [NUM_CH],
  output logic              trig_we,
  output logic [NUM_CH-1:0] cnt_sel,
  output logic              rd_any
);
  logic run_hit;

  assign run_hit = (bus_addr == ADDR_W'(RUN_OFS));
  assign trig_we = bus_wr && (bus_addr == ADDR_W'(TRIG_OFS));
  assign rd_any  = bus_rd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam int unsigned LEN_A = LEN_BASE + WORD_BYTES * i;
    localparam int unsigned CNT_A = CNT_BASE + WORD_BYTES * i;
    assign ch_wr[i].len_we = bus_wr && (bus_addr == ADDR_W'(LEN_A));
    assign ch_wr[i].run_we = bus_wr && run_hit;
    assign cnt_sel[i]      = bus_rd && (bus_addr == ADDR_W'(CNT_A));
  end
endmodule

// File: rtl/qtt_channel.sv
module qtt_channel
  import qtt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int FLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ch_wr_t           wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [FLD_W-1:0] run_fld,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             irq
);
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             irq_q;
  logic             expire;
  logic             start_ok;

  assign expire   = run_q && tick && (cnt_q <= CNT_W'(1));
  assign start_ok = (|run_fld) && (len_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (wr.len_we) begin
      len_q <= wdata;
      irq_q <= 1'b0;
      if (wdata != '0) cnt_q <= wdata;
      else             run_q <= 1'b0;
    end else if (wr.run_we) begin
      irq_q <= 1'b0;
      if (start_ok) begin
        cnt_q <= len_q;
        run_q <= 1'b1;
      end else begin
        run_q <= 1'b0;
      end
    end else if (expire) begin
      cnt_q <= len_q;
      irq_q <= 1'b1;
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
  assign irq     = irq_q;
endmodule

// File: rtl/qtt_trigger.sv
module qtt_trigger #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              req
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= trig_we && (wdata == DATA_W'(KEY));
  end

  assign req = req_q;
endmodule

// File: rtl/quad_tick_timer.sv
module quad_tick_timer
  import qtt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int FLD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] timer_irq,
  output logic              reset_req
);
  localparam int FLD_SPAN = NUM_CH * FLD_W;

  ch_wr_t                         ch_wr [NUM_CH];
  logic                           trig_we;
  logic [NUM_CH-1:0]              cnt_sel;
  logic                           rd_any;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_count;
  logic [NUM_CH-1:0]              ch_run;
  logic [DATA_W-1:0]              rd_next;
  logic [DATA_W-1:0]              rdata_q;

  qtt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .ch_wr   (ch_wr),
    .trig_we (trig_we),
    .cnt_sel (cnt_sel),
    .rd_any  (rd_any)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    qtt_channel #(.CNT_W(CNT_W), .FLD_W(FLD_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr     (ch_wr[i]),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .run_fld(bus_wdata[FLD_W*i +: FLD_W]),
      .count  (ch_count[i]),
      .running(ch_run[i]),
      .irq    (timer_irq[i])
    );
  end

  qtt_trigger #(.DATA_W(DATA_W), .KEY(TRIG_KEY)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_we(trig_we),
    .wdata  (bus_wdata),
    .req    (reset_req)
  );

  // One-hot select of the live count; unmatched offsets give zero
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cnt_sel[i]) rd_next[CNT_W-1:0] = rd_next[CNT_W-1:0] | ch_count[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_any) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

  initial begin
    if (FLD_SPAN > DATA_W) $error("start/stop fields exceed data width");
    if (CNT_W > DATA_W)    $error("count wider than data bus");
  end
endmodule

// File: rtl/quad_tick_timer_chk.sv
module quad_tick_timer_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic [NUM_CH-1:0]            timer_irq,
  input logic                         reset_req,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_count,
  input logic [NUM_CH-1:0]            ch_run
);
  // R9: the request is a single-cycle pulse
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R9: a request only follows a key write to the trigger offset
  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(bus_wr && bus_addr == ADDR_W'(8'h34)
                        && bus_wdata == DATA_W'(32'h0001_0000)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    // R5: stopped channel holds its count without writes
    p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_run[i] && !bus_wr) |=> $stable(ch_count[i]));

    // R7: pending interrupt survives cycles without writes
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_irq[i] && !bus_wr) |=> timer_irq[i]);

    // R6: interrupt rises only from a tick on a running channel
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timer_irq[i]) |-> ($past(tick) && $past(ch_run[i])));

    // R3: a running channel never sits at a zero count
    p_run_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[i] |-> (ch_count[i] != '0));
  end
endmodule

bind quad_tick_timer quad_tick_timer_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .timer_irq(timer_irq),
  .reset_req(reset_req),
  .ch_count (ch_count),
  .ch_run   (ch_run)
);

// File: tb/quad_tick_timer_test.sv
module quad_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  timer_irq;
  logic        reset_req;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  quad_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_irq(timer_irq), .reset_req(reset_req)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] len_a(int ch); return 8'(4 * ch); endfunction
  function automatic logic [7:0] cnt_a(int ch); return 8'(8'h14 + 4 * ch); endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rd(cnt_a(c), v); check("R1 count after reset", v, 0);
    end
    check("R1 irq after reset", 32'(timer_irq), 0);
    check("R1 reset_req after reset", 32'(reset_req), 0);
    wr(8'h10, 32'hFFFF);                 // zero lengths: must not run
    ticks(3);
    rd(cnt_a(2), v); check("R4 zero length stays stopped", v, 0);

    // R2 length load without starting
    wr(len_a(0), 5);
    rd(cnt_a(0), v); check("R2 length loads count", v, 5);
    ticks(2);
    rd(cnt_a(0), v); check("R5 stopped ignores tick", v, 5);

    // R6 sweep: every channel, lengths 1..6
    for (int c = 0; c < 4; c++) begin
      for (int L = 1; L <= 6; L++) begin
        wr(len_a(c), L);
        wr(8'h10, 32'h1 << (4 * c));
        for (int t = 1; t <= 2 * L; t++) begin
          ticks(1);
          rd(cnt_a(c), v);
          check("R6 count after ticks", v, L - (t % L));
          check("R6 irq after ticks", 32'(timer_irq), (t >= L) ? (32'h1 << c) : 0);
        end
      end
    end
    wr(8'h10, 0);
    check("R4 run write clears irq", 32'(timer_irq), 0);

    // R5 no tick, no movement while running
    wr(len_a(1), 9);
    wr(8'h10, 32'h0000_0080);            // ch1 field = 8
    repeat (4) @(negedge clk);
    rd(cnt_a(1), v); check("R5 running holds without tick", v, 9);
    ticks(3);
    rd(cnt_a(1), v); check("R5 running counts ticks", v, 6);

    // R3 zero length stops and freezes
    wr(len_a(1), 0);
    ticks(2);
    rd(cnt_a(1), v); check("R3 zero length freezes count", v, 6);
    wr(8'h10, 32'h0000_00F0);
    ticks(2);
    rd(cnt_a(1), v); check("R4 zero length blocks start", v, 6);

    // R4 field stop freezes count
    wr(len_a(2), 7);
    wr(8'h10, 32'h0000_0200);
    ticks(2);
    wr(8'h10, 32'h0000_F0FF);            // ch2 field zero
    ticks(3);
    rd(cnt_a(2), v); check("R4 zero field stops channel", v, 5);

    // R10 independence: ch1 and ch3 only
    wr(len_a(0), 10); wr(len_a(1), 10); wr(len_a(2), 10); wr(len_a(3), 3);
    wr(8'h10, 32'h0000_F0F0);
    ticks(3);
    rd(cnt_a(0), v); check("R10 ch0 untouched", v, 10);
    rd(cnt_a(1), v); check("R10 ch1 runs", v, 7);
    rd(cnt_a(2), v); check("R10 ch2 untouched", v, 10);
    rd(cnt_a(3), v); check("R10 ch3 runs", v, 3);
    check("R10 only ch3 irq", 32'(timer_irq), 32'h8);

    // R7 irq kept through other channel length writes, cleared by own
    wr(len_a(1), 4);
    check("R7 other length write keeps irq", 32'(timer_irq), 32'h8);
    ticks(10);
    check("R7 sticky across ticks", 32'(timer_irq), 32'hA);
    wr(len_a(3), 3);
    check("R7 own length write clears irq", 32'(timer_irq), 32'h2);
    wr(8'h10, 32'h0);
    check("R7 run write clears all irq", 32'(timer_irq), 0);

    // R8 other offsets read zero
    rd(8'h00, v); check("R8 length offset reads 0", v, 0);
    rd(8'h10, v); check("R8 run offset reads 0", v, 0);
    rd(8'h24, v); check("R8 gap offset reads 0", v, 0);
    rd(8'h34, v); check("R8 trigger offset reads 0", v, 0);

    // R9 trigger
    bus_wr = 1'b1; bus_addr = 8'h34; bus_wdata = 32'h0001_0000;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 key write pulses", 32'(reset_req), 1);
    @(negedge clk);
    check("R9 pulse lasts one cycle", 32'(reset_req), 0);
    begin
      logic [31:0] bad [4] = '{32'h0001_0001, 32'h0, 32'h0000_1000, 32'h0003_0000};
      for (int k = 0; k < 4; k++) begin
        bus_wr = 1'b1; bus_addr = 8'h34; bus_wdata = bad[k];
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9 wrong value ignored", 32'(reset_req), 0);
      end
    end
    bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h0001_0000;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 key at wrong offset ignored", 32'(reset_req), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule